// File: doc/BRIEF.md
# DTMF Dual-Tone Sample Synthesizer

This block turns a 5-bit tone code into a stream of digital audio samples carrying one low-group (row) tone and one high-group (column) tone, or a single tone from either group, or silence. Two phase accumulators step once per clock of the 3.579545 MHz system clock. Each accumulator feeds a quarter-wave sine lookup. The two signed tone samples are added around a mid-scale offset, and the column tone is lifted by about 2 dB over the row tone.

The controlling logic writes a code by pulsing `code_we` with the code on `code_in`. Every write clears both phase accumulators, so each tone starts at phase zero. The silence code and the unused codes hold the output at mid-scale.

Samples leave on a valid/ready stream. `out_valid` rises on the first clock after reset and then stays high, because a fresh sample is always on hand. A sample is transferred on a clock edge where `out_valid` and `out_ready` are both high, and the next sample is captured on that same edge. While `out_ready` is low, `out_data` holds its value. The tone generators keep running during a stall, so a sink that stalls skips samples and the pitch does not change.

Top module: `dtmf_synth`

## Requirements
- R1: While reset is asserted and at its release, `out_valid` is 0 and `out_data` equals the mid-scale value 4096.
- R2: Codes 0 to 15 produce a dual tone (row Hz + column Hz):
  - 1: 697+1209, 2: 697+1336, 3: 697+1477
  - 4: 770+1209, 5: 770+1336, 6: 770+1477
  - 7: 852+1209, 8: 852+1336, 9: 852+1477
  - 10: 941+1336, 11: 941+1209, 12: 941+1477
  - 13: 697+1633, 14: 770+1633, 15: 852+1633
  - 0: 941+1633
- R3: Codes 16 to 19 produce only the row tone 697, 770, 852 or 941 Hz. Codes 20 to 23 produce only the column tone 1209, 1336, 1477 or 1633 Hz.
- R4: Code 31 (silence) and the unused codes 24 to 30 hold `out_data` at exactly 4096 from the second edge after the write onward. They also keep both accumulators cleared.
- R5: A code write on edge E0 restarts both tones at phase zero. On edge E0+k (k ≥ 2) the captured sample follows `4096 + 1600·sin(2π·fr·(k−2)/3579545) + G·1600·sin(2π·fc·(k−2)/3579545)` within ±50 LSB. This bounds each tone's frequency error well under 0.75 %.
- R6: The column tone is scaled by G = 161/128 (about 2.0 dB) relative to the row tone, whose peak is 1600. No row sample exceeds ±1600, and no column sample exceeds ±2012.
- R7: `out_valid` stays high from the first edge after reset. While `out_valid` is high and `out_ready` is low, `out_data` is held on the next edge.
- R8: `code_in` has no effect on any edge where `code_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 3.579545 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| code_we | input | 1 | Write strobe for the tone code |
| code_in | input | 5 | Tone code, taken when `code_we` is high |
| out_valid | output | 1 | Sample stream valid |
| out_ready | input | 1 | Sample stream ready from the sink |
| out_data | output | 13 | Unsigned sample, mid-scale 4096 |

## Verification
All 24 tone codes are first written in order and each is held long enough for several tone periods, with the sink always ready. This separates every row/column pairing, because a swapped or off-by-one frequency drifts out of the ±50 LSB window within a few hundred cycles, and a wrong column gain fails on the single-column codes. Silence and unused codes are checked for an exact mid-scale output. Random code sequences then run under random sink stalls, with garbage on `code_in` while the strobe is low. These runs show whether a stall freezes the data, and whether the tones stay phase-continuous while stalled samples are dropped.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int ROW_HZ [4] = '{697, 770, 852, 941};
  localparam int COL_HZ [4] = '{1209, 1336, 1477, 1633};

  typedef struct packed {
    logic       row_en;
    logic [1:0] row_sel;
    logic       col_en;
    logic [1:0] col_sel;
  } tone_sel_t;

  // Phase step per clock, rounded: hz * 2^pw / clk_hz
  function automatic longint phase_inc(input int hz, input int clk_hz, input int pw);
    return ((longint'(hz) << pw) + longint'(clk_hz / 2)) / longint'(clk_hz);
  endfunction

  // Quarter-wave sine magnitude for entry idx of n, sampled at bin centres
  function automatic int qsine(input int idx, input int n, input int peak);
    real x, x2, s;
    x  = (real'(idx) + 0.5) * 3.14159265358979 / (2.0 * real'(n));
    x2 = x * x;
    s  = x * (1.0 - x2 / 6.0 * (1.0 - x2 / 20.0 * (1.0 - x2 / 42.0 * (1.0 - x2 / 72.0))));
    return $rtoi(s * real'(peak) + 0.5);
  endfunction

endpackage

// File: rtl/dtmf_code_map.sv
module dtmf_code_map (
  input  logic [4:0]          code,
  output dtmf_pkg::tone_sel_t sel
);
  always_comb begin
    sel = '0;
    case (code)
      5'd1:  sel = '{1'b1, 2'd0, 1'b1, 2'd0};
      5'd2:  sel = '{1'b1, 2'd0, 1'b1, 2'd1};
      5'd3:  sel = '{1'b1, 2'd0, 1'b1, 2'd2};
      5'd4:  sel = '{1'b1, 2'd1, 1'b1, 2'd0};
      5'd5:  sel = '{1'b1, 2'd1, 1'b1, 2'd1};
      5'd6:  sel = '{1'b1, 2'd1, 1'b1, 2'd2};
      5'd7:  sel = '{1'b1, 2'd2, 1'b1, 2'd0};
      5'd8:  sel = '{1'b1, 2'd2, 1'b1, 2'd1};
      5'd9:  sel = '{1'b1, 2'd2, 1'b1, 2'd2};
      5'd10: sel = '{1'b1, 2'd3, 1'b1, 2'd1};
      5'd11: sel = '{1'b1, 2'd3, 1'b1, 2'd0};
      5'd12: sel = '{1'b1, 2'd3, 1'b1, 2'd2};
      5'd13: sel = '{1'b1, 2'd0, 1'b1, 2'd3};
      5'd14: sel = '{1'b1, 2'd1, 1'b1, 2'd3};
      5'd15: sel = '{1'b1, 2'd2, 1'b1, 2'd3};
      5'd0:  sel = '{1'b1, 2'd3, 1'b1, 2'd3};
      5'd16, 5'd17, 5'd18, 5'd19: sel = '{1'b1, code[1:0], 1'b0, 2'd0};
      5'd20, 5'd21, 5'd22, 5'd23: sel = '{1'b0, 2'd0, 1'b1, code[1:0]};
      default: sel = '0;
    endcase
  end
endmodule

// File: rtl/dtmf_tone_chan.sv
module dtmf_tone_chan #(
  parameter int CLK_HZ   = 3579545,
  parameter int PHASE_W  = 24,
  parameter int QBITS    = 6,
  parameter int MAG_W    = 11,
  parameter int PEAK     = 1600,
  parameter int GAIN_NUM = 128,
  parameter int GAIN_SH  = 7,
  parameter bit IS_COL   = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    clear,
  input  logic [1:0]              sel,
  output logic signed [MAG_W:0]   samp
);
  localparam int QN     = 1 << QBITS;
  localparam int PROD_W = MAG_W + $clog2(GAIN_NUM + 1);
  localparam int LIM    = (PEAK * GAIN_NUM) >> GAIN_SH;

  logic [PHASE_W-1:0] inc_tab [4];
  logic [MAG_W-1:0]   qtab [QN];

  for (genvar g = 0; g < 4; g++) begin : g_inc
    assign inc_tab[g] = PHASE_W'(dtmf_pkg::phase_inc(
                          IS_COL ? dtmf_pkg::COL_HZ[g] : dtmf_pkg::ROW_HZ[g],
                          CLK_HZ, PHASE_W));
  end

  for (genvar g = 0; g < QN; g++) begin : g_sine
    assign qtab[g] = MAG_W'(dtmf_pkg::qsine(g, QN, PEAK));
  end

  logic [PHASE_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n)                acc <= '0;
    else if (clear || !enable) acc <= '0;
    else                       acc <= acc + inc_tab[sel];
  end

  logic [QBITS-1:0]     idx_raw, idx;
  logic [MAG_W-1:0]     mag, scaled;
  logic [PROD_W-1:0]    prod;
  logic signed [MAG_W:0] val;

  always_comb begin
    idx_raw = acc[PHASE_W-3 -: QBITS];
    idx     = acc[PHASE_W-2] ? ~idx_raw : idx_raw;
    mag     = qtab[idx];
    prod    = PROD_W'(mag) * PROD_W'(GAIN_NUM);
    scaled  = MAG_W'(prod >> GAIN_SH);
    val     = acc[PHASE_W-1] ? -$signed({1'b0, scaled}) : $signed({1'b0, scaled});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) samp <= '0;
    else        samp <= enable ? val : '0;
  end

  // R4
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (samp == '0));

  // R6
  peak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp <= LIM) && (samp >= -LIM));

endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth #(
  parameter int CLK_HZ   = 3579545,
  parameter int PHASE_W  = 24,
  parameter int QBITS    = 6,
  parameter int MAG_W    = 11,
  parameter int ROW_PEAK = 1600,
  parameter int COL_GAIN = 161,
  parameter int GAIN_SH  = 7,
  parameter int OUT_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             code_we,
  input  logic [4:0]       code_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int MID    = 1 << (OUT_W - 1);
  localparam int SAMP_W = MAG_W + 1;
  localparam logic [4:0] CODE_OFF = 5'd31;

  logic [4:0]          code_r;
  dtmf_pkg::tone_sel_t sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       code_r <= CODE_OFF;
    else if (code_we) code_r <= code_in;
  end

  dtmf_code_map i_map (.code(code_r), .sel(sel));

  logic signed [SAMP_W-1:0] samp [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    dtmf_tone_chan #(
      .CLK_HZ  (CLK_HZ),
      .PHASE_W (PHASE_W),
      .QBITS   (QBITS),
      .MAG_W   (MAG_W),
      .PEAK    (ROW_PEAK),
      .GAIN_NUM(ch == 1 ? COL_GAIN : (1 << GAIN_SH)),
      .GAIN_SH (GAIN_SH),
      .IS_COL  (ch == 1)
    ) i_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .enable(ch == 1 ? sel.col_en : sel.row_en),
      .clear (code_we),
      .sel   (ch == 1 ? sel.col_sel : sel.row_sel),
      .samp  (samp[ch])
    );
  end

  logic signed [OUT_W:0] mix;
  always_comb begin
    mix = $signed((OUT_W+1)'(MID)) + (OUT_W+1)'(samp[0]) + (OUT_W+1)'(samp[1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= OUT_W'(MID);
    end else if (!out_valid || out_ready) begin
      out_valid <= 1'b1;
      out_data  <= mix[OUT_W-1:0];
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  // R2
  dual_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_r < 5'd16) |-> (sel.row_en && sel.col_en));

  // R3
  single_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_r[4:3] == 2'b10) |-> $onehot({sel.row_en, sel.col_en}));

  // R4
  silent_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_r[4:3] == 2'b11) |-> !(sel.row_en || sel.col_en));

endmodule

// File: tb/test_dtmf_synth.sv
module test_dtmf_synth;
  localparam int    CLK_HZ = 3579545;
  localparam int    MID    = 4096;
  localparam real   RPK    = 1600.0;
  localparam real   GAIN   = 161.0 / 128.0;
  localparam real   TWO_PI = 6.28318530717959;
  localparam int    TOL    = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        code_we = 1'b0;
  logic [4:0]  code_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [12:0] out_data;

  int vectors = 0;
  int fails = 0;
  int k = 100;
  int cur = 31;
  int prev = MID;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dtmf_synth i_dtmf_synth (
    .clk(clk), .rst_n(rst_n), .code_we(code_we), .code_in(code_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic void freqs(input int c, output int fr, output int fc);
    int rows [4] = '{697, 770, 852, 941};
    int cols [4] = '{1209, 1336, 1477, 1633};
    fr = 0; fc = 0;
    if (c >= 1 && c <= 9) begin fr = rows[(c-1)/3]; fc = cols[(c-1)%3]; end
    else if (c == 10) begin fr = 941; fc = 1336; end
    else if (c == 11) begin fr = 941; fc = 1209; end
    else if (c == 12) begin fr = 941; fc = 1477; end
    else if (c >= 13 && c <= 15) begin fr = rows[c-13]; fc = 1633; end
    else if (c == 0) begin fr = 941; fc = 1633; end
    else if (c >= 16 && c <= 19) fr = rows[c-16];
    else if (c >= 20 && c <= 23) fc = cols[c-20];
  endfunction

  function automatic int model(input int c, input int n);
    int fr, fc;
    real t, v;
    freqs(c, fr, fc);
    t = real'(n) / real'(CLK_HZ);
    v = real'(MID);
    if (fr != 0) v = v + RPK * $sin(TWO_PI * real'(fr) * t);
    if (fc != 0) v = v + GAIN * RPK * $sin(TWO_PI * real'(fc) * t);
    return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
  endfunction

  function automatic string req_of(input int c);
    if (c < 16) return "R2/R5/R6";
    if (c < 24) return "R3/R5/R6";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (code %0d, k %0d)", req, act, exp, cur, k);
    end
  endtask

  task automatic observe(input bit rdy);
    int e, tol, d;
    check(out_valid == 1'b1, "R7 valid", int'(out_valid), 1);
    if (!rdy) begin
      check(int'(out_data) == prev, "R7 stall hold", int'(out_data), prev);
    end else if (k >= 2) begin
      e = model(cur, k - 2);
      tol = (cur >= 24) ? 0 : TOL;
      d = int'(out_data) - e;
      if (d < 0) d = -d;
      check(d <= tol, req_of(cur), int'(out_data), e);
    end
    prev = int'(out_data);
  endtask

  task automatic load(input int c);
    @(negedge clk);
    code_we = 1'b1; code_in = 5'(c); out_ready = 1'b1;
    @(posedge clk); #1;
    cur = c; k = 0;
    prev = int'(out_data);
  endtask

  // code_in carries noise whenever code_we is low (R8)
  task automatic run(input int n, input int ready_pct);
    bit rdy;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      code_we = 1'b0;
      code_in = 5'($urandom % 32);
      out_ready = (($urandom % 100) < ready_pct);
      rdy = out_ready;
      @(posedge clk); #1;
      k++;
      observe(rdy);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    check(int'(out_data) == MID, "R1 data in reset", int'(out_data), MID);
    @(negedge clk); rst_n = 1'b1;
    check(out_valid == 1'b0, "R1 valid at release", int'(out_valid), 0);
    @(posedge clk); #1;
    prev = int'(out_data);
    // R4 idle after reset stays silent
    run(20, 100);

    // R2 R3: every tone code in turn, sink always ready
    for (int c = 0; c < 24; c++) begin
      load(c);
      run(1500, 100);
    end

    // R4: silence and unused codes after a tone
    load(5);  run(300, 100);
    load(31); run(200, 100);
    load(9);  run(300, 100);
    load(26); run(200, 100);
    load(24); run(100, 100);

    // R7 R8: random codes under random stalls
    for (int j = 0; j < 40; j++) begin
      load(int'($urandom % 32));
      run(500 + int'($urandom % 1500), 30 + int'($urandom % 70));
    end

    // R7: long stall then resume
    load(13);
    run(200, 100);
    run(300, 0);
    run(300, 100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule